// File: doc/BRIEF.md
# JTAG Register-Chain Frame Decoder

This block sits behind a JTAG TAP controller and turns the serial data-register traffic into accesses to a small debug register file. It receives the TAP strobes for capture, shift and update of the data register, the TDI bit, and two decoded instruction flags. One flag selects a chain. The other selects debug access to the chosen chain. Every incoming frame is shifted least-significant bit first and closes with an 8-bit CRC. No frame takes effect unless both its length and its CRC are correct.

With the chain-select instruction active, a short frame chooses which debug chain the following debug frames address. With the debug instruction active and the register chain chosen, each frame carries an address, a direction flag and a data word. A write is committed to one of six 32-bit registers one clock after update. A read captures the addressed register at update. That value is shifted out on TDO during the next debug frame, followed by a CRC over the outgoing word. The block runs on the TCK clock domain. Its reset is synchronous and active high.

Top module: `jtag_regchain_dec`

## Requirements
- R1: While rst is high at a clock edge, the block sets chain_id to 4'hF, crc_err to 0 and tdo to 0, and clears every register to 0.
- R2: A chain-select frame (sel_chain high) is 12 bits. The first 4 bits are the new chain identifier, LSB first, and the next 8 bits are the CRC field, LSB first. If the frame is accepted, chain_id shows the new identifier in the cycle after the update_dr edge. At any other time chain_id holds its value.
- R3: A frame whose bit count since capture_dr is not exactly the frame length, or whose CRC field does not match, is rejected. A rejected frame does not change chain_id, any register or the read latch, and it sets crc_err to 1. An accepted frame sets crc_err to 0. crc_err changes only at update_dr.
- R4: Register frames are decoded only when sel_debug is high, sel_chain is low and chain_id equals 4'h4. A register frame is 46 bits, shifted LSB first: bits 0-4 are the address, bit 5 is the direction flag, bits 6-37 are the data and bits 38-45 are the CRC field. sel_chain and sel_debug are never high together.
- R5: An accepted frame with direction flag 1 writes its data to the addressed register. The write completes by the following clock edge. Address 0 is the mode register, 1 the trigger select, 2 the qualifier select, 3 the stop select, 4 the record select and 5 the monitor control register.
- R6: An accepted frame with direction flag 0 ignores its data field and copies the addressed register into a read latch at update_dr. On the next decoded frame, the latch is captured at capture_dr. tdo carries latch bit k, LSB first, in the cycle after the k-th shift_dr edge (k from 0 to 31), even when that capture comes one cycle after the previous update.
- R7: In the next 8 shift cycles, tdo carries the CRC of those 32 output bits, LSB first. tdo is 0 in later shift cycles and in every cycle without shift_dr.
- R8: A read of an address of 6 or higher latches 32'hFFFFFFFF and exposes no register content.
- R9: A write to an address of 6 or higher changes no register.
- R10: The CRC uses the polynomial x^8+x^2+x+1, starts at 0 and processes one bit per step: fb = crc[7] xor bit, then crc = {crc[6:0],0} xor (fb ? 8'h07 : 0). The incoming CRC covers every bit before the CRC field, in shift order.
- R11: A debug frame sent while chain_id is not 4'h4 has no effect: no write, no read, crc_err unchanged and tdo 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | TCK clock |
| rst | input | 1 | Synchronous active-high TAP reset |
| capture_dr | input | 1 | One-cycle capture strobe for the data register |
| shift_dr | input | 1 | High for each data-register shift cycle |
| update_dr | input | 1 | One-cycle update strobe for the data register |
| sel_chain | input | 1 | Chain-select instruction is active |
| sel_debug | input | 1 | Debug instruction is active |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Registered serial data out |
| chain_id | output | 4 | Currently selected chain identifier |
| crc_err | output | 1 | Outcome of the last frame that was checked (1 means rejected) |

## Verification
The commit of a pending write and the capture_dr of the next frame can fall on the same clock edge. This happens when capture_dr arrives one cycle after update_dr. The bench provokes it by sending a write with no idle gap and then a read frame at once. The read frame must shift out the word latched by the earlier read, not the freshly written data, and a further read must return the new value. A reference model in the bench, built from frame bit queues, predicts tdo, chain_id and crc_err in every cycle. Directed read-backs also check register contents, the output CRC and the trailing zeros.

// File: rtl/jrc_pkg.sv
package jrc_pkg;

  localparam int CRC_W = 8;

  // One serial CRC step: shift left, fold the feedback bit through the polynomial.
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                input logic b,
                                                input logic [CRC_W-1:0] poly);
    logic fb;
    fb = c[CRC_W-1] ^ b;
    return {c[CRC_W-2:0], 1'b0} ^ ({CRC_W{fb}} & poly);
  endfunction

endpackage

// File: rtl/jrc_frame_rx.sv
module jrc_frame_rx
  import jrc_pkg::*;
#(
  parameter int              SR_W = 46,
  parameter int              CNT_W = 6,
  parameter logic [CRC_W-1:0] POLY = 8'h07
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic              shift,
  input  logic              tdi,
  input  logic [CNT_W-1:0]  cover_len,
  output logic [SR_W-1:0]   sr,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic [CRC_W-1:0]  crc_calc
);

  // Bits enter at the top and walk down, so after a full frame the first
  // bit shifted sits at index 0 and the CRC field occupies the top bits.
  always_ff @(posedge clk) begin
    if (rst) begin
      sr       <= '0;
      bit_cnt  <= '0;
      crc_calc <= '0;
    end else if (capture) begin
      bit_cnt  <= '0;
      crc_calc <= '0;
    end else if (shift) begin
      sr <= {tdi, sr[SR_W-1:1]};
      if (bit_cnt != '1)
        bit_cnt <= bit_cnt + 1'b1;
      if (bit_cnt < cover_len)
        crc_calc <= crc_step(crc_calc, tdi, POLY);
    end
  end

endmodule

// File: rtl/jrc_tdo_tx.sv
module jrc_tdo_tx
  import jrc_pkg::*;
#(
  parameter int              DATA_W = 32,
  parameter logic [CRC_W-1:0] POLY = 8'h07
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic              shift,
  input  logic              active,
  input  logic [DATA_W-1:0] load_data,
  output logic              tdo
);

  localparam int TOTAL  = DATA_W + CRC_W;
  localparam int OCNT_W = $clog2(TOTAL + 1);

  logic [DATA_W-1:0] osr;
  logic [OCNT_W-1:0] ocnt;
  logic [CRC_W-1:0]  ocrc;

  always_ff @(posedge clk) begin
    if (rst) begin
      osr  <= '0;
      ocnt <= '0;
      ocrc <= '0;
      tdo  <= 1'b0;
    end else if (capture) begin
      osr  <= load_data;
      ocnt <= '0;
      ocrc <= '0;
      tdo  <= 1'b0;
    end else if (shift && active) begin
      if (ocnt < OCNT_W'(DATA_W)) begin
        tdo  <= osr[0];
        ocrc <= crc_step(ocrc, osr[0], POLY);
        osr  <= osr >> 1;
      end else if (ocnt < OCNT_W'(TOTAL)) begin
        tdo  <= ocrc[0];
        ocrc <= ocrc >> 1;
      end else begin
        tdo <= 1'b0;
      end
      if (ocnt != '1)
        ocnt <= ocnt + 1'b1;
    end else begin
      tdo <= 1'b0;
    end
  end

endmodule

// File: rtl/jrc_regfile.sv
module jrc_regfile #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter int NREG   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs[g] <= '0;
      else if (we && waddr == ADDR_W'(g))
        regs[g] <= wdata;
    end
  end

  // Unmapped addresses read as all ones.
  always_comb begin
    rdata = '1;
    for (int i = 0; i < NREG; i++)
      if (raddr == ADDR_W'(i))
        rdata = regs[i];
  end

endmodule

// File: rtl/jtag_regchain_dec.sv
module jtag_regchain_dec
  import jrc_pkg::*;
#(
  parameter int               ADDR_W      = 5,
  parameter int               DATA_W      = 32,
  parameter int               CHAIN_W     = 4,
  parameter int               NREG        = 6,
  parameter logic [3:0]       REG_CHAIN   = 4'h4,
  parameter logic [3:0]       CHAIN_RESET = 4'hF,
  parameter logic [CRC_W-1:0] CRC_POLY    = 8'h07
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               capture_dr,
  input  logic               shift_dr,
  input  logic               update_dr,
  input  logic               sel_chain,
  input  logic               sel_debug,
  input  logic               tdi,
  output logic               tdo,
  output logic [CHAIN_W-1:0] chain_id,
  output logic               crc_err
);

  localparam int REG_FRAME = ADDR_W + 1 + DATA_W + CRC_W;
  localparam int CHN_FRAME = CHAIN_W + CRC_W;
  localparam int SR_W      = REG_FRAME;
  localparam int CNT_W     = $clog2(REG_FRAME + 1);

  logic [SR_W-1:0]   sr;
  logic [CNT_W-1:0]  bit_cnt;
  logic [CRC_W-1:0]  crc_calc;
  logic [CNT_W-1:0]  cover_len;
  logic              dbg_act;
  logic              len_ok;
  logic              frame_ok;
  logic [CRC_W-1:0]  crc_field;
  logic [CHAIN_W-1:0] chain_field;
  logic [ADDR_W-1:0] f_addr;
  logic              f_rw;
  logic [DATA_W-1:0] f_data;

  logic [CHAIN_W-1:0] chain_q;
  logic               err_q;
  logic               pend_wr;
  logic [ADDR_W-1:0]  pend_addr;
  logic [DATA_W-1:0]  pend_data;
  logic [DATA_W-1:0]  rd_latch;
  logic [DATA_W-1:0]  rf_rdata;

  assign dbg_act   = sel_debug && !sel_chain && (chain_q == CHAIN_W'(REG_CHAIN));
  assign cover_len = sel_chain ? CNT_W'(CHN_FRAME - CRC_W) : CNT_W'(REG_FRAME - CRC_W);
  assign len_ok    = sel_chain ? (bit_cnt == CNT_W'(CHN_FRAME)) : (bit_cnt == CNT_W'(REG_FRAME));

  assign crc_field   = sr[SR_W-1 -: CRC_W];
  assign chain_field = sr[SR_W-CRC_W-1 -: CHAIN_W];
  assign f_addr      = sr[ADDR_W-1:0];
  assign f_rw        = sr[ADDR_W];
  assign f_data      = sr[ADDR_W+1 +: DATA_W];
  assign frame_ok    = len_ok && (crc_calc == crc_field);

  jrc_frame_rx #(
    .SR_W  (SR_W),
    .CNT_W (CNT_W),
    .POLY  (CRC_POLY)
  ) i_rx (
    .clk       (clk),
    .rst       (rst),
    .capture   (capture_dr),
    .shift     (shift_dr),
    .tdi       (tdi),
    .cover_len (cover_len),
    .sr        (sr),
    .bit_cnt   (bit_cnt),
    .crc_calc  (crc_calc)
  );

  jrc_regfile #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .NREG   (NREG)
  ) i_rf (
    .clk   (clk),
    .rst   (rst),
    .we    (pend_wr),
    .waddr (pend_addr),
    .wdata (pend_data),
    .raddr (f_addr),
    .rdata (rf_rdata)
  );

  jrc_tdo_tx #(
    .DATA_W (DATA_W),
    .POLY   (CRC_POLY)
  ) i_tx (
    .clk       (clk),
    .rst       (rst),
    .capture   (capture_dr),
    .shift     (shift_dr),
    .active    (dbg_act),
    .load_data (rd_latch),
    .tdo       (tdo)
  );

  // Frame commit: chain latch, error flag, write staging and read latch.
  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q   <= CHAIN_W'(CHAIN_RESET);
      err_q     <= 1'b0;
      pend_wr   <= 1'b0;
      pend_addr <= '0;
      pend_data <= '0;
      rd_latch  <= '0;
    end else begin
      pend_wr <= 1'b0;
      if (update_dr) begin
        if (sel_chain) begin
          err_q <= !frame_ok;
          if (frame_ok)
            chain_q <= chain_field;
        end else if (dbg_act) begin
          err_q <= !frame_ok;
          if (frame_ok) begin
            if (f_rw) begin
              pend_wr   <= 1'b1;
              pend_addr <= f_addr;
              pend_data <= f_data;
            end else begin
              rd_latch <= rf_rdata;
            end
          end
        end
      end
    end
  end

  assign chain_id = chain_q;
  assign crc_err  = err_q;

endmodule

// File: rtl/jrc_checker.sv
module jrc_checker #(
  parameter int         CHAIN_W     = 4,
  parameter logic [3:0] REG_CHAIN   = 4'h4,
  parameter logic [3:0] CHAIN_RESET = 4'hF
) (
  input logic               clk,
  input logic               rst,
  input logic               shift_dr,
  input logic               update_dr,
  input logic               sel_chain,
  input logic               sel_debug,
  input logic               tdo,
  input logic [CHAIN_W-1:0] chain_id,
  input logic               crc_err
);

  // R1: a reset edge leaves the outputs in their idle values
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (chain_id == CHAIN_W'(CHAIN_RESET) && !crc_err && !tdo));

  // R2: the chain identifier moves only on a chain-select update
  a_r2_chain_hold: assert property (@(posedge clk) disable iff (rst)
    !(update_dr && sel_chain) |=> $stable(chain_id));

  // R3: the error flag moves only at update
  a_r3_err_hold: assert property (@(posedge clk) disable iff (rst)
    !update_dr |=> $stable(crc_err));

  // R4: the two instruction flags are exclusive
  a_r4_flags_excl: assert property (@(posedge clk) disable iff (rst)
    !(sel_chain && sel_debug));

  // R7: no shift, no data on tdo
  a_r7_tdo_quiet: assert property (@(posedge clk) disable iff (rst)
    !shift_dr |=> !tdo);

  // R11: a debug update on another chain leaves flag and chain alone
  a_r11_other_chain: assert property (@(posedge clk) disable iff (rst)
    (update_dr && sel_debug && !sel_chain && chain_id != CHAIN_W'(REG_CHAIN))
      |=> ($stable(crc_err) && $stable(chain_id)));

endmodule

bind jtag_regchain_dec jrc_checker #(
  .CHAIN_W     (CHAIN_W),
  .REG_CHAIN   (REG_CHAIN),
  .CHAIN_RESET (CHAIN_RESET)
) i_chk (
  .clk       (clk),
  .rst       (rst),
  .shift_dr  (shift_dr),
  .update_dr (update_dr),
  .sel_chain (sel_chain),
  .sel_debug (sel_debug),
  .tdo       (tdo),
  .chain_id  (chain_id),
  .crc_err   (crc_err)
);

// File: tb/test_jtag_regchain_dec.sv
`timescale 1ns/1ps
module test_jtag_regchain_dec;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0;
  logic sel_chain = 1'b0, sel_debug = 1'b0, tdi = 1'b0;
  logic tdo;
  logic [3:0] chain_id;
  logic crc_err;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  jtag_regchain_dec i_jtag_regchain_dec (
    .clk(clk), .rst(rst), .capture_dr(capture_dr), .shift_dr(shift_dr),
    .update_dr(update_dr), .sel_chain(sel_chain), .sel_debug(sel_debug),
    .tdi(tdi), .tdo(tdo), .chain_id(chain_id), .crc_err(crc_err));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // CRC straight from the polynomial definition (R10)
  function automatic logic [7:0] bench_crc(input logic [63:0] v, input int n);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < n; i++) begin
      if (c[7] ^ v[i]) c = (c << 1) ^ 8'h07;
      else             c = c << 1;
    end
    return c;
  endfunction

  function automatic logic [63:0] reg_vec(input logic [4:0] a, input logic rw,
                                          input logic [31:0] d, input logic bad);
    logic [63:0] v = '0;
    v[4:0]   = a;
    v[5]     = rw;
    v[37:6]  = d;
    v[45:38] = bench_crc(v, 38) ^ {7'd0, bad};
    return v;
  endfunction

  function automatic logic [63:0] chain_vec(input logic [3:0] id, input logic bad);
    logic [63:0] v = '0;
    v[3:0]  = id;
    v[11:4] = bench_crc(v, 4) ^ {7'd0, bad};
    return v;
  endfunction

  // ---------------- behavioural reference model ----------------
  logic m_tdo = 1'b0;
  logic [3:0] m_chain = 4'hF;
  logic m_err = 1'b0;
  logic [31:0] m_regs [6];
  logic [31:0] m_rd = '0;
  logic m_pend = 1'b0;
  int m_paddr = 0;
  logic [31:0] m_pdata = '0;
  logic inq[$];
  logic outq[$];

  task automatic m_update(input bit act);
    int n;
    logic [63:0] v;
    bit ok;
    n = inq.size();
    v = '0;
    for (int i = 0; i < n && i < 64; i++) v[i] = inq[i];
    ok = (n >= 8) && (n <= 64) && (bench_crc(v, n - 8) == v[n-8 +: 8]);
    if (sel_chain) begin
      ok = ok && (n == 12);
      m_err = !ok;
      if (ok) m_chain = v[3:0];
    end else if (act) begin
      ok = ok && (n == 46);
      m_err = !ok;
      if (ok) begin
        if (v[5]) begin
          m_pend = 1'b1; m_paddr = int'(v[4:0]); m_pdata = v[37:6];
        end else begin
          m_rd = (v[4:0] < 5'd6) ? m_regs[v[4:0]] : 32'hFFFF_FFFF;
        end
      end
    end
  endtask

  always @(posedge clk) begin
    bit act;
    logic [7:0] c;
    if (rst) begin
      m_tdo = 0; m_chain = 4'hF; m_err = 0; m_rd = '0; m_pend = 0;
      for (int i = 0; i < 6; i++) m_regs[i] = '0;
      inq.delete(); outq.delete();
    end else begin
      act = sel_debug && !sel_chain && (m_chain == 4'h4);
      if (m_pend) begin
        if (m_paddr < 6) m_regs[m_paddr] = m_pdata;
        m_pend = 0;
      end
      if (shift_dr && act) m_tdo = (outq.size() > 0) ? outq.pop_front() : 1'b0;
      else m_tdo = 1'b0;
      if (capture_dr) begin
        inq.delete(); outq.delete();
        c = 8'h00;
        for (int i = 0; i < 32; i++) begin
          outq.push_back(m_rd[i]);
          if (c[7] ^ m_rd[i]) c = (c << 1) ^ 8'h07; else c = c << 1;
        end
        for (int i = 0; i < 8; i++) outq.push_back(c[i]);
      end
      if (shift_dr) inq.push_back(tdi);
      if (update_dr) m_update(act);
    end
  end

  bit run_cmp = 1'b0;
  always @(negedge clk) begin
    if (run_cmp && !rst) begin
      chk("R6 tdo vs model", {63'd0, tdo}, {63'd0, m_tdo});
      chk("R2 chain_id vs model", {60'd0, chain_id}, {60'd0, m_chain});
      chk("R3 crc_err vs model", {63'd0, crc_err}, {63'd0, m_err});
    end
  end

  // ---------------- stimulus ----------------
  task automatic send(input logic [63:0] v, input int n, input int gap, output logic [63:0] got);
    got = '0;
    capture_dr = 1'b1;
    @(negedge clk);
    capture_dr = 1'b0;
    for (int i = 0; i < n; i++) begin
      shift_dr = 1'b1; tdi = v[i];
      @(negedge clk);
      got[i] = tdo;
    end
    shift_dr = 1'b0; tdi = 1'b0; update_dr = 1'b1;
    @(negedge clk);
    update_dr = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic pick_chain(input logic [3:0] id, input logic bad);
    logic [63:0] g;
    sel_debug = 1'b0; sel_chain = 1'b1;
    send(chain_vec(id, bad), 12, 2, g);
    sel_chain = 1'b0; sel_debug = 1'b1;
  endtask

  task automatic check_read(input logic [4:0] a, input logic [31:0] exp, input string tag);
    logic [63:0] g;
    send(reg_vec(a, 1'b0, 32'h0, 1'b0), 46, 2, g);
    send(reg_vec(a, 1'b0, 32'h0, 1'b0), 46, 2, g);
    chk(tag, {32'd0, g[31:0]}, {32'd0, exp});
    chk("R7 output crc", {56'd0, g[39:32]}, {56'd0, bench_crc({32'd0, exp}, 32)});
    chk("R7 trailing zeros", {58'd0, g[45:40]}, 64'd0);
  endtask

  function automatic logic [31:0] wval(input int i);
    return 32'h3C5A_0000 + 32'(i) * 32'h0000_0101 + 32'h8000_0001;
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [63:0] g;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    run_cmp = 1'b1;
    chk("R1 chain reset", {60'd0, chain_id}, 64'hF);
    chk("R1 err reset", {63'd0, crc_err}, 64'd0);
    chk("R1 tdo reset", {63'd0, tdo}, 64'd0);

    pick_chain(4'h4, 1'b0);
    chk("R2 chain select", {60'd0, chain_id}, 64'h4);
    chk("R10 good crc accepted", {63'd0, crc_err}, 64'd0);

    for (int i = 0; i < 6; i++) check_read(5'(i), 32'h0, "R1 register cleared");

    for (int i = 0; i < 6; i++) send(reg_vec(5'(i), 1'b1, wval(i), 1'b0), 46, 2, g);
    for (int i = 0; i < 6; i++) check_read(5'(i), wval(i), "R5 R4 write readback");

    check_read(5'd9, 32'hFFFF_FFFF, "R8 unmapped read");
    check_read(5'd31, 32'hFFFF_FFFF, "R8 top address read");

    send(reg_vec(5'd7, 1'b1, 32'hDEAD_0007, 1'b0), 46, 2, g);
    for (int i = 0; i < 6; i++) check_read(5'(i), wval(i), "R9 unmapped write dropped");

    send(reg_vec(5'd2, 1'b1, 32'h0BAD_0002, 1'b1), 46, 2, g);
    chk("R3 bad crc flagged", {63'd0, crc_err}, 64'd1);
    check_read(5'd2, wval(2), "R3 bad crc write suppressed");
    chk("R3 good frame clears flag", {63'd0, crc_err}, 64'd0);

    send(reg_vec(5'd0, 1'b1, 32'h0BAD_0000, 1'b0), 45, 2, g);
    chk("R3 short frame flagged", {63'd0, crc_err}, 64'd1);
    check_read(5'd0, wval(0), "R3 short frame suppressed");

    send(reg_vec(5'd1, 1'b0, 32'hFFFF_FFFF, 1'b0), 46, 2, g);
    check_read(5'd1, wval(1), "R6 read data field ignored");

    // write commit and next capture on the same edge
    send(reg_vec(5'd3, 1'b1, 32'h1234_5678, 1'b0), 46, 0, g);
    send(reg_vec(5'd3, 1'b0, 32'h0, 1'b0), 46, 2, g);
    chk("R6 capture right after update shows old latch", {32'd0, g[31:0]}, {32'd0, wval(1)});
    check_read(5'd3, 32'h1234_5678, "R5 write committed");

    pick_chain(4'h2, 1'b0);
    chk("R2 chain switch", {60'd0, chain_id}, 64'h2);
    send(reg_vec(5'd0, 1'b1, 32'hCAFE_0000, 1'b1), 46, 2, g);
    chk("R11 flag unchanged off chain", {63'd0, crc_err}, 64'd0);
    send(reg_vec(5'd0, 1'b0, 32'h0, 1'b0), 46, 2, g);
    chk("R11 tdo quiet off chain", g, 64'd0);
    pick_chain(4'h5, 1'b1);
    chk("R3 bad chain select kept", {60'd0, chain_id}, 64'h2);
    chk("R3 bad chain select flagged", {63'd0, crc_err}, 64'd1);
    pick_chain(4'h4, 1'b0);
    check_read(5'd0, wval(0), "R11 no write off chain");

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule